// File: doc/BRIEF.md
# Soft-Start and Thermal Restart Sequencer

This block orders the start-up of a step-down converter. After an enable request with a healthy supply, it first holds the soft-start capacitor shorted for a fixed time. It then waits out the rest of a fixed start delay. Finally it releases switching, with the capacitor charging so that its voltage serves as the regulation reference. When the soft-start comparator reports that the ramp has reached the reference level, the reference select hands over to the fixed internal reference for good.

The block also handles shutdown and restart. A junction temperature at or above the trip point stops switching and parks the sequencer. It restarts only when the temperature has fallen to the lower resume point, and the restart is always a complete new soft-start that begins with the discharge phase.

Dropping enable gives standby. Losing the supply-good indication forces the disabled phase at once. Time is counted in ticks of a microsecond strobe, and both durations are parameters.

Top module: `sstart_seq`

## Requirements
- R1: During and right after reset, every output is low (disabled phase).
- R2: From the disabled phase, with enable and supply-good both high, the next clock enters discharge. In discharge only `ss_discharge_o` is high.
- R3: Discharge lasts exactly DISCH_TICKS tick strobes, counted from the clock after it is entered.
- R4: Switching starts exactly START_TICKS tick strobes after discharge is entered. Between the end of discharge and the start of switching, every output is low.
- R5: In the ramp phase, `ss_charge_o`, `switch_en_o` and `ss_window_o` are high, and `ref_internal_o` is low (the ramp is the reference).
- R6: While in the ramp, `ss_at_ref_i` high moves the sequencer to regulation on the next clock. Regulation has `ref_internal_o` high and `ss_window_o` low. It stays there whatever `ss_at_ref_i` does afterwards.
- R7: A temperature code at or above TRIP_C (170) in any active phase drives all outputs low within two clocks. A code of 169 has no effect.
- R8: After a trip, nothing restarts while the code stays above RESUME_C (155). A code at or below 155 re-enters discharge within two clocks, and a full DISCH_TICKS discharge follows.
- R9: Enable low in any phase gives the disabled phase on the next clock. Enable high again gives discharge on the following clock.
- R10: Supply-good low gives the disabled phase on the next clock from any phase, and the sequencer stays there while supply-good is low.
- R11: `ss_discharge_o` is never high together with `ss_charge_o` or `switch_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-clock timing strobe, one per time unit |
| en_i | input | 1 | Converter enable |
| supply_ok_i | input | 1 | Supply undervoltage monitor reports a valid supply |
| ss_at_ref_i | input | 1 | Soft-start voltage has reached the reference level |
| tj_code_i | input | TEMP_W | Junction temperature, unsigned degrees C |
| ss_discharge_o | output | 1 | Soft-start capacitor discharge switch |
| ss_charge_o | output | 1 | Soft-start charge current enable |
| ref_internal_o | output | 1 | 1 selects the internal reference, 0 the soft-start ramp |
| switch_en_o | output | 1 | Power switch activity allowed |
| ss_window_o | output | 1 | Soft-start window: nominal current limit, foldback held off |

## Verification
The assertions assume that every input is already synchronous to `clk` and that `us_tick` is a single-cycle strobe. They also assume the comparator and temperature inputs are free of glitches within a cycle. The stimulus drives all inputs on the falling edge and generates the strobe from a clock divider, one pulse every four clocks. The temperature steps directly between codes that straddle both thresholds, including the codes one step inside each threshold.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_DISCH = 3'd1,
    PH_SETUP = 3'd2,
    PH_RAMP  = 3'd3,
    PH_REG   = 3'd4,
    PH_THERM = 3'd5
  } phase_e;
endpackage

// File: rtl/ssq_rst_sync.sv
module ssq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ssq_thermal_guard.sv
module ssq_thermal_guard #(
  parameter int TEMP_W   = 8,
  parameter int TRIP_C   = 170,
  parameter int RESUME_C = 155
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] tj_code,
  output logic              hot
);
  localparam logic [TEMP_W-1:0] TRIP_V   = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] RESUME_V = TEMP_W'(RESUME_C);

  logic hot_d;
  logic hot_q;

  always_comb begin
    hot_d = hot_q;
    if (tj_code >= TRIP_V)        hot_d = 1'b1;
    else if (tj_code <= RESUME_V) hot_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot_q <= 1'b0;
    else        hot_q <= hot_d;
  end

  assign hot = hot_q;

  AST_HOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_q && tj_code > RESUME_V) |=> hot_q); // R8
  AST_COOL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hot_q && tj_code < TRIP_V) |=> !hot_q); // R7
endmodule

// File: rtl/ssq_tick_timer.sv
module ssq_tick_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          count_en,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_d;
  logic [CW-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)                      cnt_d = '0;
    else if (count_en && cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/ssq_phase_fsm.sv
module ssq_phase_fsm
  import ssq_pkg::*;
#(
  parameter int CW          = 10,
  parameter int DISCH_TICKS = 530,
  parameter int SETUP_TICKS = 110
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          supply_ok,
  input  logic          at_ref,
  input  logic          hot,
  input  logic [CW-1:0] count,
  output logic          tmr_restart,
  output logic          tmr_en,
  output logic          ss_dis,
  output logic          ss_chg,
  output logic          ref_int,
  output logic          sw_en,
  output logic          ss_win
);
  localparam logic [CW-1:0] DISCH_LAST = CW'(DISCH_TICKS - 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_TICKS - 1);

  phase_e state_q;
  phase_e state_d;
  logic   active;

  assign active = (state_q == PH_DISCH) || (state_q == PH_SETUP) ||
                  (state_q == PH_RAMP)  || (state_q == PH_REG);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_OFF:   if (en && supply_ok) state_d = PH_DISCH;
      PH_DISCH: if (tick && count == DISCH_LAST) state_d = PH_SETUP;
      PH_SETUP: if (tick && count == SETUP_LAST) state_d = PH_RAMP;
      PH_RAMP:  if (at_ref) state_d = PH_REG;
      PH_REG:   state_d = PH_REG;
      PH_THERM: if (!hot) state_d = PH_DISCH;
      default:  state_d = PH_OFF;
    endcase
    if (active && hot)               state_d = PH_THERM;
    if (state_q != PH_OFF && !en)    state_d = PH_OFF;
    if (!supply_ok)                  state_d = PH_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_OFF;
    else        state_q <= state_d;
  end

  assign tmr_restart = (state_d != state_q);
  assign tmr_en      = tick && ((state_q == PH_DISCH) || (state_q == PH_SETUP));

  assign ss_dis  = (state_q == PH_DISCH);
  assign ss_chg  = (state_q == PH_RAMP) || (state_q == PH_REG);
  assign sw_en   = (state_q == PH_RAMP) || (state_q == PH_REG);
  assign ref_int = (state_q == PH_REG);
  assign ss_win  = (state_q == PH_RAMP);

  AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (state_q == PH_OFF)); // R10
  AST_ENABLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == PH_OFF)); // R9
  AST_REF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_REG && supply_ok && en && !hot) |=> (state_q == PH_REG)); // R6
  AST_RAMP_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == PH_RAMP) |-> ($past(state_q) == PH_SETUP)); // R4
  AST_DISCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_DISCH) |-> (count <= DISCH_LAST)); // R3
  AST_HOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (hot && active) |=> !sw_en); // R7
  AST_DIS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ss_dis |-> !(ss_chg || sw_en)); // R11
endmodule

// File: rtl/sstart_seq.sv
module sstart_seq #(
  parameter int TEMP_W      = 8,
  parameter int TRIP_C      = 170,
  parameter int RESUME_C    = 155,
  parameter int DISCH_TICKS = 530,
  parameter int START_TICKS = 640
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              en_i,
  input  logic              supply_ok_i,
  input  logic              ss_at_ref_i,
  input  logic [TEMP_W-1:0] tj_code_i,
  output logic              ss_discharge_o,
  output logic              ss_charge_o,
  output logic              ref_internal_o,
  output logic              switch_en_o,
  output logic              ss_window_o
);
  // START_TICKS must exceed DISCH_TICKS; the difference is the setup wait.
  localparam int SETUP_TICKS = START_TICKS - DISCH_TICKS;
  localparam int CW          = $clog2(START_TICKS + 1);

  logic          rst_sync_n;
  logic          hot;
  logic          tmr_restart;
  logic          tmr_en;
  logic [CW-1:0] count;

  ssq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ssq_thermal_guard #(
    .TEMP_W   (TEMP_W),
    .TRIP_C   (TRIP_C),
    .RESUME_C (RESUME_C)
  ) u_therm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tj_code (tj_code_i),
    .hot     (hot)
  );

  ssq_tick_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .restart  (tmr_restart),
    .count_en (tmr_en),
    .count    (count)
  );

  ssq_phase_fsm #(
    .CW          (CW),
    .DISCH_TICKS (DISCH_TICKS),
    .SETUP_TICKS (SETUP_TICKS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick        (us_tick),
    .en          (en_i),
    .supply_ok   (supply_ok_i),
    .at_ref      (ss_at_ref_i),
    .hot         (hot),
    .count       (count),
    .tmr_restart (tmr_restart),
    .tmr_en      (tmr_en),
    .ss_dis      (ss_discharge_o),
    .ss_chg      (ss_charge_o),
    .ref_int     (ref_internal_o),
    .sw_en       (switch_en_o),
    .ss_win      (ss_window_o)
  );
endmodule

// File: tb/sstart_seq_bench.sv
module sstart_seq_bench;
  localparam int DIS_T   = 6;
  localparam int START_T = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       en = 1'b0;
  logic       ok = 1'b0;
  logic       at_ref = 1'b0;
  logic [7:0] temp = 8'd25;
  logic       dis, chg, refi, sw, win;
  logic [1:0] div = 2'd0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] v;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  sstart_seq #(
    .DISCH_TICKS (DIS_T),
    .START_TICKS (START_T)
  ) u_sstart_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .us_tick        (tick),
    .en_i           (en),
    .supply_ok_i    (ok),
    .ss_at_ref_i    (at_ref),
    .tj_code_i      (temp),
    .ss_discharge_o (dis),
    .ss_charge_o    (chg),
    .ref_internal_o (refi),
    .switch_en_o    (sw),
    .ss_window_o    (win)
  );

  always @(negedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
  end

  // Expected vector order: {discharge, charge, internal_ref, switch, window}
  task automatic expect_out(input logic [4:0] v, input string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if ({dis, chg, refi, sw, win} !== e.v) begin
          failures++;
          $display("FAIL %s actual=%b expected=%b", e.tag,
                   {dis, chg, refi, sw, win}, e.v);
        end
      end
    end
  end

  // Counts strobes from discharge entry until switching starts.
  task automatic run_to_switch(output int dis_t, output int all_t);
    bit started = 1'b0;
    dis_t = 0;
    all_t = 0;
    for (int i = 0; i < 3000; i++) begin
      #2;
      if (sw) break;
      if (dis) started = 1'b1;
      if (tick && started) begin
        all_t++;
        if (dis) dis_t++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int dt, at;
    repeat (3) @(negedge clk);
    expect_out(5'b00000, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_out(5'b00000, "R1 after reset");

    en = 1'b1; ok = 1'b1;
    @(negedge clk);
    expect_out(5'b10000, "R2 discharge entry");
    run_to_switch(dt, at);
    chk(dt, DIS_T, "R3 discharge length");
    chk(at, START_T, "R4 start delay");
    expect_out(5'b01011, "R5 ramp");
    repeat (10) @(negedge clk);
    expect_out(5'b01011, "R5 ramp held");
    at_ref = 1'b1;
    @(negedge clk);
    expect_out(5'b01110, "R6 regulation");
    at_ref = 1'b0;
    repeat (5) @(negedge clk);
    expect_out(5'b01110, "R6 stays internal");

    temp = 8'd169;
    repeat (5) @(negedge clk);
    expect_out(5'b01110, "R7 169 no trip");
    temp = 8'd170;
    repeat (2) @(negedge clk);
    expect_out(5'b00000, "R7 trip");
    temp = 8'd160;
    repeat (40) @(negedge clk);
    expect_out(5'b00000, "R8 no restart at 160");
    temp = 8'd156;
    repeat (5) @(negedge clk);
    expect_out(5'b00000, "R8 no restart at 156");
    temp = 8'd155;
    repeat (2) @(negedge clk);
    expect_out(5'b10000, "R8 restart discharge");
    run_to_switch(dt, at);
    chk(dt, DIS_T, "R8 fresh discharge length");
    at_ref = 1'b1;
    expect_out(5'b01110, "R6 regulation again");
    @(negedge clk);
    at_ref = 1'b0;

    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    expect_out(5'b00000, "R9 standby");
    repeat (10) @(negedge clk);
    expect_out(5'b00000, "R9 standby held");
    en = 1'b1;
    @(negedge clk);
    expect_out(5'b10000, "R9 re-enable discharge");

    ok = 1'b0;
    @(negedge clk);
    expect_out(5'b00000, "R10 supply loss in discharge");
    repeat (5) @(negedge clk);
    expect_out(5'b00000, "R10 held off");
    ok = 1'b1;
    @(negedge clk);
    expect_out(5'b10000, "R2 supply back");
    run_to_switch(dt, at);
    @(negedge clk);
    ok = 1'b0;
    @(negedge clk);
    expect_out(5'b00000, "R10 supply loss in ramp");

    ok = 1'b1;
    @(negedge clk);
    expect_out(5'b10000, "R11 discharge alone");
    temp = 8'd200;
    repeat (2) @(negedge clk);
    expect_out(5'b00000, "R7 trip in discharge");
    temp = 8'd100;
    repeat (2) @(negedge clk);
    expect_out(5'b10000, "R8 restart after cool");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule